// File: doc/BRIEF.md
# Banked Memory Composer

This block presents one logical single-port synchronous memory of width `W`, depth `D` and write-mask granularity `M`. It builds that memory from a two-dimensional array of smaller library memories, each of width `LW`, depth `LD` and mask granularity `LM`. The data word is cut into contiguous bit slices, and each slice is held in its own column of library instances. The address space is cut into rows of `LD` words, called banks. One instance sits at each bank/slice crossing.

The upper address bits choose a bank, and only that bank's instances are enabled. The lower `log2(LD)` address bits go to every instance. The logical write mask is rebuilt for every slice to suit the library mask granularity. This works when the logical granularity is finer than the library's, when it is coarser, and when a single library instance is wider than the whole logical word. Library bits that carry no logical data are written as zero, and their read values are dropped.

Illegal granularity combinations stop elaboration. These are: a library granularity that is not a power of two, a coarser logical granularity that is not a whole multiple of the library one, and a finer logical granularity that does not divide the library one. A behavioural library memory model is part of the block.

Top module: `mem_composer`

## Requirements
- R1: After reset is released, and before any read has been issued, `rd_data` is all zeros.
- R2: A read (`req`=1, `wr`=0) of address `a` presents the word stored at `a` on `rd_data` at the first clock edge after the request, so it can be sampled in the following cycle. Back-to-back reads each return their own address.
- R3: A write with every mask bit set stores the full `W`-bit word, and later reads return it, for every address `0..D-1` across all banks.
- R4: Write-mask bit `j` enables data bits `j*M` to `j*M+M-1` of the word. The bits under a clear mask bit keep their earlier value.
- R5: When `M` is smaller than `LM`, each instance stores exactly `M` logical bits, one mask field per instance. Masked writes to one field leave the neighbouring fields unchanged.
- R6: When `M` is a multiple of a smaller `LM`, each library mask bit copies the logical mask bit that covers its bits. Masked writes behave as in R4.
- R7: When `LW` is larger than `W`, one instance holds the whole word. Library mask bits whose first covered bit is at or above `W` are driven to 0, and masked reads and writes behave as in R4.
- R8: `rd_data` changes only in the cycle after a read request. Idle cycles and write cycles leave it unchanged.
- R9: A write with an all-zero mask changes no stored bit.
- R10: A request enables the instances of exactly one bank, the one selected by `addr / LD`. A write therefore leaves the word at the same in-bank offset of every other bank unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request for this cycle |
| wr | input | 1 | 1 = write, 0 = read, valid while `req` is 1 |
| addr | input | clog2(D) | Logical word address, below `D` |
| wr_data | input | W | Write data |
| wr_mask | input | W/M | Write mask, bit j covers data bits j*M to j*M+M-1 |
| rd_data | output | W | Read data, one cycle after a read request |

## Verification
The checker assumes that the address is always below `D` while a request is present. Under that assumption the bank decode must pick exactly one bank. The stimulus keeps to this rule by drawing every address modulo the logical depth, including the last partial bank.

The checker also assumes that `wr` only has meaning when `req` is set. The bench drives three copies of the block with the same requests: a fine-mask geometry, a coarse-mask geometry with a partial last bank, and a geometry whose single instance is wider than the word. The three are compared against flat reference arrays in the bench.

// File: rtl/mc_pkg.sv
package mc_pkg;

  // Bits of one library instance that a single slice occupies.
  function automatic int slice_width(int m, int lm, int lw);
    return (m < lm) ? m : lw;
  endfunction

  function automatic int div_up(int a, int b);
    return (a + b - 1) / b;
  endfunction

  function automatic bit pow2(int v);
    return (v > 0) && ((v & (v - 1)) == 0);
  endfunction

endpackage

// File: rtl/mc_lib_sram.sv
module mc_lib_sram #(
  parameter int LW = 8,
  parameter int LD = 8,
  parameter int LM = 4,
  localparam int LMW = LW / LM,
  localparam int LAW = $clog2(LD)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ce,
  input  logic           we,
  input  logic [LAW-1:0] addr,
  input  logic [LW-1:0]  wdata,
  input  logic [LMW-1:0] wmask,
  output logic [LW-1:0]  rdata
);

  logic [LW-1:0] store [LD];
  logic [LW-1:0] rdata_d, rdata_q;

  always_ff @(posedge clk) begin
    if (ce && we) begin
      for (int k = 0; k < LMW; k++) begin
        if (wmask[k]) store[addr][k*LM +: LM] <= wdata[k*LM +: LM];
      end
    end
  end

  always_comb begin
    rdata_d = rdata_q;
    if (ce && !we) rdata_d = store[addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/mc_slice_map.sv
module mc_slice_map #(
  parameter int W   = 12,
  parameter int M   = 2,
  parameter int LW  = 8,
  parameter int LM  = 4,
  parameter int EW  = 2,
  parameter int LSB = 0,
  parameter int NB  = 3,
  localparam int MW  = W / M,
  localparam int LMW = LW / LM
) (
  input  logic [W-1:0]           wdata,
  input  logic [MW-1:0]          wmask,
  output logic [LW-1:0]          lib_wdata,
  output logic [LMW-1:0]         lib_wmask,
  input  logic [NB-1:0][LW-1:0]  lib_rdata,
  output logic [NB-1:0][W-1:0]   placed
);

  // Write data: only bits that carry a logical bit are driven, the rest are zero.
  for (genvar b = 0; b < LW; b++) begin : g_wd
    if (b < EW && LSB + b < W) begin : g_live
      assign lib_wdata[b] = wdata[LSB + b];
    end else begin : g_tie
      assign lib_wdata[b] = 1'b0;
    end
  end

  // Mask remap: library mask bit k covers library bits from k*LM upward.
  for (genvar k = 0; k < LMW; k++) begin : g_wm
    localparam int I = k * LM;
    if (M < LM && I >= EW) begin : g_fine_tie
      assign lib_wmask[k] = 1'b0;
    end else if (LSB + I >= W) begin : g_wide_tie
      assign lib_wmask[k] = 1'b0;
    end else begin : g_pick
      assign lib_wmask[k] = wmask[(LSB + I) / M];
    end
  end

  // Read placement: put this slice's bits back at their logical position.
  for (genvar b = 0; b < NB; b++) begin : g_rb
    for (genvar p = 0; p < W; p++) begin : g_rp
      if (p >= LSB && p < LSB + EW) begin : g_in
        assign placed[b][p] = lib_rdata[b][p - LSB];
      end else begin : g_out
        assign placed[b][p] = 1'b0;
      end
    end
  end

endmodule

// File: rtl/mc_bank_decode.sv
module mc_bank_decode #(
  parameter int AW  = 5,
  parameter int LAW = 3,
  parameter int NB  = 3,
  parameter int XW  = 6,
  localparam int BW = XW - LAW
) (
  input  logic           req,
  input  logic [AW-1:0]  addr,
  output logic [LAW-1:0] lib_addr,
  output logic [BW-1:0]  bank_idx,
  output logic [NB-1:0]  bank_sel
);

  logic [XW-1:0] addr_x;

  assign addr_x   = XW'(addr);
  assign lib_addr = addr_x[LAW-1:0];
  assign bank_idx = addr_x[XW-1:LAW];

  for (genvar b = 0; b < NB; b++) begin : g_sel
    assign bank_sel[b] = req && (bank_idx == BW'(b));
  end

endmodule

// File: rtl/mc_read_select.sv
module mc_read_select #(
  parameter int W  = 12,
  parameter int NB = 3,
  parameter int BW = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_en,
  input  logic [BW-1:0]        bank_idx,
  input  logic [NB-1:0][W-1:0] bank_rdata,
  output logic [W-1:0]         rdata
);

  logic [BW-1:0] rbank_d, rbank_q;

  always_comb begin
    rbank_d = rbank_q;
    if (rd_en) rbank_d = bank_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rbank_q <= '0;
    else        rbank_q <= rbank_d;
  end

  always_comb begin
    rdata = '0;
    for (int b = 0; b < NB; b++) begin
      if (rbank_q == BW'(b)) rdata = bank_rdata[b];
    end
  end

endmodule

// File: rtl/mem_composer.sv
module mem_composer
  import mc_pkg::*;
#(
  parameter int W  = 12,
  parameter int D  = 24,
  parameter int M  = 2,
  parameter int LW = 8,
  parameter int LD = 8,
  parameter int LM = 4,
  localparam int AW = $clog2(D),
  localparam int MW = W / M
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wr_data,
  input  logic [MW-1:0] wr_mask,
  output logic [W-1:0]  rd_data
);

  localparam int LAW = $clog2(LD);
  localparam int LMW = LW / LM;
  localparam int EW  = slice_width(M, LM, LW);
  localparam int NS  = div_up(W, EW);
  localparam int NB  = div_up(D, LD);
  localparam int XW  = ((AW > LAW) ? AW : LAW) + 1;
  localparam int BW  = XW - LAW;

  // Elaboration-time legality of the geometry.
  if (!pow2(LM)) begin : g_bad_lm
    $error("library mask granularity must be a power of two");
  end
  if (!pow2(LD)) begin : g_bad_ld
    $error("library depth must be a power of two");
  end
  if (LW % LM != 0 || W % M != 0) begin : g_bad_div
    $error("widths must be whole multiples of their mask granularity");
  end
  if (M >= LM && (M % LM) != 0) begin : g_bad_coarse
    $error("logical granularity is not a multiple of library granularity");
  end
  if (M < LM && (LM % M) != 0) begin : g_bad_fine
    $error("library granularity is not a multiple of logical granularity");
  end

  logic [LAW-1:0]               lib_addr;
  logic [BW-1:0]                bank_idx;
  logic [NB-1:0]                bank_sel;
  logic [NS-1:0][LW-1:0]        lib_wd;
  logic [NS-1:0][LMW-1:0]       lib_wm;
  logic [NS-1:0][NB-1:0][LW-1:0] lib_rd;
  logic [NS-1:0][NB-1:0][W-1:0] placed;
  logic [NB-1:0][W-1:0]         bank_rdata;
  logic                         rd_en;

  assign rd_en = req && !wr;

  mc_bank_decode #(
    .AW(AW), .LAW(LAW), .NB(NB), .XW(XW)
  ) u_dec (
    .req      (req),
    .addr     (addr),
    .lib_addr (lib_addr),
    .bank_idx (bank_idx),
    .bank_sel (bank_sel)
  );

  for (genvar s = 0; s < NS; s++) begin : g_slice
    mc_slice_map #(
      .W(W), .M(M), .LW(LW), .LM(LM), .EW(EW), .LSB(s * EW), .NB(NB)
    ) u_map (
      .wdata     (wr_data),
      .wmask     (wr_mask),
      .lib_wdata (lib_wd[s]),
      .lib_wmask (lib_wm[s]),
      .lib_rdata (lib_rd[s]),
      .placed    (placed[s])
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
      mc_lib_sram #(
        .LW(LW), .LD(LD), .LM(LM)
      ) u_lib (
        .clk   (clk),
        .rst_n (rst_n),
        .ce    (bank_sel[b]),
        .we    (wr),
        .addr  (lib_addr),
        .wdata (lib_wd[s]),
        .wmask (lib_wm[s]),
        .rdata (lib_rd[s][b])
      );
    end
  end

  always_comb begin
    for (int b = 0; b < NB; b++) begin
      bank_rdata[b] = '0;
      for (int s = 0; s < NS; s++) bank_rdata[b] = bank_rdata[b] | placed[s][b];
    end
  end

  mc_read_select #(
    .W(W), .NB(NB), .BW(BW)
  ) u_rsel (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .bank_idx   (bank_idx),
    .bank_rdata (bank_rdata),
    .rdata      (rd_data)
  );

endmodule

// File: rtl/mem_composer_chk.sv
module mem_composer_chk #(
  parameter int AW = 5,
  parameter int NB = 3,
  parameter int W  = 12,
  parameter int D  = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req,
  input logic          wr,
  input logic [AW-1:0] addr,
  input logic [W-1:0]  rd_data,
  input logic [NB-1:0] bank_sel
);

  // R2 (input assumption): requests stay inside the logical depth.
  p_addr_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (int'(addr) < D));

  // R10: never more than one bank enabled.
  p_one_bank_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_sel));

  // R10: a legal request enables exactly one bank.
  p_bank_on_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req && int'(addr) < D) |-> ($countones(bank_sel) == 1));

  // R10: no bank enabled without a request.
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> (bank_sel == '0));

  // R8: read data holds unless a read was issued.
  p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(req && !wr) |=> $stable(rd_data));

  // R1: read data is zero when reset lifts.
  p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (rd_data == '0));

endmodule

bind mem_composer mem_composer_chk #(
  .AW(AW), .NB(NB), .W(W), .D(D)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req      (req),
  .wr       (wr),
  .addr     (addr),
  .rd_data  (rd_data),
  .bank_sel (bank_sel)
);

// File: tb/tb_mem_composer.sv
`timescale 1ns/1ps
module tb_mem_composer;

  localparam int W  = 12;
  localparam int D  = 24;
  localparam int AW = 5;

  logic          clk;
  logic          rst_n;
  logic          req;
  logic          wr;
  logic [AW-1:0] addr;
  logic [W-1:0]  wr_data;
  logic [5:0]    g;
  logic [W-1:0]  rd_a, rd_b, rd_c;

  logic [W-1:0] ref_a [D];
  logic [W-1:0] ref_b [D];
  logic [W-1:0] ref_c [D];

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 0;
  logic [31:0] seed = 32'h1234_5678;

  // 200 MHz
  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Fine mask: M=2 < LM=4, three banks, six slices.
  mem_composer #(.W(W), .D(D), .M(2), .LW(8), .LD(8), .LM(4)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr),
    .wr_data(wr_data), .wr_mask(g), .rd_data(rd_a));

  // Coarse mask: M=4 > LM=2, partial second bank.
  mem_composer #(.W(W), .D(D), .M(4), .LW(4), .LD(16), .LM(2)) dut_coarse (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr),
    .wr_data(wr_data), .wr_mask({g[4], g[2], g[0]}), .rd_data(rd_b));

  // Wide instance: LW=16 > W=12, one instance covers everything.
  mem_composer #(.W(W), .D(D), .M(4), .LW(16), .LD(32), .LM(4)) dut_wide (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr),
    .wr_data(wr_data), .wr_mask({g[4], g[2], g[0]}), .rd_data(rd_c));

  function automatic logic [W-1:0] bits_fine(logic [5:0] m);
    logic [W-1:0] r;
    for (int j = 0; j < W; j++) r[j] = m[j / 2];
    return r;
  endfunction

  function automatic logic [W-1:0] bits_coarse(logic [5:0] m);
    logic [W-1:0] r;
    for (int j = 0; j < W; j++) r[j] = m[(j / 4) * 2];
    return r;
  endfunction

  function automatic logic [31:0] next_rand(logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic check(string req_tag, string who, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req_tag, who, act, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge with the write done.
  task automatic do_write(int a, logic [W-1:0] d, logic [5:0] m);
    logic [W-1:0] fa, fc;
    req = 1'b1; wr = 1'b1; addr = AW'(a); wr_data = d; g = m;
    @(negedge clk);
    req = 1'b0; wr = 1'b0;
    fa = bits_fine(m);
    fc = bits_coarse(m);
    ref_a[a] = (ref_a[a] & ~fa) | (d & fa);
    ref_b[a] = (ref_b[a] & ~fc) | (d & fc);
    ref_c[a] = (ref_c[a] & ~fc) | (d & fc);
  endtask

  // Called at a negedge; the value is sampled one negedge later.
  task automatic do_read(int a, string ta, string tb, string tc);
    req = 1'b1; wr = 1'b0; addr = AW'(a);
    @(negedge clk);
    req = 1'b0;
    check(ta, "fine",   rd_a, ref_a[a]);
    check(tb, "coarse", rd_b, ref_b[a]);
    check(tc, "wide",   rd_c, ref_c[a]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [W-1:0] held_a, held_b, held_c;
    rst_n = 1'b0; req = 1'b0; wr = 1'b0; addr = '0; wr_data = '0; g = '0;
    for (int a = 0; a < D; a++) begin
      ref_a[a] = '0; ref_b[a] = '0; ref_c[a] = '0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state of the read port
    check("R1", "fine",   rd_a, '0);
    check("R1", "coarse", rd_b, '0);
    check("R1", "wide",   rd_c, '0);

    // R3: full-mask fill of every address, then read all back (R2 back-to-back)
    for (int a = 0; a < D; a++) do_write(a, W'((a * 32'h1A7) ^ 32'h5C3), 6'h3F);
    for (int a = 0; a < D; a++) do_read(a, "R3", "R3", "R3");
    for (int a = D - 1; a >= 0; a--) do_read(a, "R2", "R2", "R2");

    // R10: write offset 3 of bank 0, other banks at offset 3 untouched
    do_write(3, 12'hA5A, 6'h3F);
    do_read(11, "R10", "R10", "R10");
    do_read(19, "R10", "R10", "R10");
    do_read(3,  "R10", "R10", "R10");

    // R9: zero mask changes nothing
    do_write(5, 12'hFFF, 6'h00);
    do_read(5, "R9", "R9", "R9");
    do_write(20, 12'h000, 6'h00);
    do_read(20, "R9", "R9", "R9");

    // R4: one mask bit at a time
    do_write(9, 12'h000, 6'h3F);
    for (int j = 0; j < 6; j++) begin
      do_write(9, 12'hFFF, 6'(1 << j));
      do_read(9, "R4", "R4", "R4");
    end

    // R8: read data holds through idle and write cycles
    do_read(7, "R8", "R8", "R8");
    held_a = rd_a; held_b = rd_b; held_c = rd_c;
    @(negedge clk);
    check("R8", "fine",   rd_a, held_a);
    check("R8", "coarse", rd_b, held_b);
    check("R8", "wide",   rd_c, held_c);
    do_write(7, ~ref_a[7], 6'h3F);
    check("R8", "fine",   rd_a, held_a);
    check("R8", "coarse", rd_b, held_b);
    check("R8", "wide",   rd_c, held_c);

    // R5/R6/R7: random masked writes interleaved with reads
    for (int n = 0; n < 800; n++) begin
      seed = next_rand(seed);
      do_write(int'(seed[7:0]) % D, seed[19:8], seed[25:20]);
      seed = next_rand(seed);
      do_read(int'(seed[7:0]) % D, "R5", "R6", "R7");
    end
    for (int a = 0; a < D; a++) do_read(a, "R5", "R6", "R7");

    finish_run();
  end

endmodule